// File: doc/BRIEF.md
# Super I/O Configuration Port Controller

This block is the configuration front end of a legacy peripheral-controller device as a host sees it over a byte-wide I/O bus. Two adjacent addresses form the interface. The lower one is an index port that names a register. The upper one is a data port that reads or writes the register the index names. After reset the register file is locked. A host opens it with a two-byte key written to the index port, and closes it again with a different two-byte key.

While the register file is open, one global register holds a logical-device number. That number decides which per-device bank the other indices reach. Each logical device has an activate bit and a 16-bit I/O base address, and both drive output pins directly. When the logical-device number is zero, one further global control byte can be reached; it holds interrupt-enable and clock predivide settings. The bus is a plain strobe interface with no back-pressure. A write takes effect at the clock edge where its strobe is sampled. A read answers with a one-cycle valid pulse on the following cycle, and the host cannot stall it.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset, `cfg_open` is 0, every bit of `dev_en` is 0, all of `dev_base` is 0 and `glob_ctrl` is 0x00.
- R2: Two consecutive index-port writes of 0x80 and then 0x86 set `cfg_open` to 1 on the cycle after the second write. Data-port traffic does not take part in key matching.
- R3: While the block is locked, if the byte after 0x80 is not 0x86, the matcher returns to idle and the block stays locked. If that byte is itself 0x80, it counts as the first byte of a new attempt, so the sequence 0x80, 0x80, 0x86 opens the block.
- R4: While the block is locked, data-port writes and index-port writes change no register. A read of either port returns 0xFF.
- R5: Two consecutive index-port writes of 0x68 and then 0x08 clear `cfg_open` on the next cycle. If any other byte follows 0x68, the block stays open. The device outputs keep their values when the block locks.
- R6: Index 0x07 is the logical-device number. It can be written with any byte, and a read returns the value last written.
- R7: Index 0x30 of the selected device is its activate register. Bit 0 of a write drives `dev_en[k]`, where k is the logical-device number minus FIRST_LDN. A read returns {7'b0, bit}.
- R8: Indices 0x60 and 0x61 of the selected device hold bits 15:8 and bits 7:0 of its base address. That address appears on `dev_base[16k+15:16k]` and can be read back.
- R9: Index 0x29 reaches `glob_ctrl` only while the logical-device number is 0x00. Writing it under any other number has no effect, and a read under any other number returns 0x00.
- R10: While the block is open, a read of an unimplemented index, or of a per-device index when no device is selected, returns 0x00. A write to such an index changes no output.
- R11: A read strobe on either port gives `rd_valid` = 1 with the data on the next cycle. Strobes to any other address are ignored and give no `rd_valid`.
- R12: While the block is open, a read of the index port returns the index that was last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | ADDR_W | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after `io_rd` |
| rd_data | output | 8 | Read data |
| cfg_open | output | 1 | Register file is open |
| dev_en | output | NUM_LDN | Activate bit per logical device |
| dev_base | output | 16*NUM_LDN | Base address per logical device, packed |
| glob_ctrl | output | 8 | Global control byte |

## Verification
Every write acts at the clock edge where its strobe is sampled. `cfg_open`, `dev_en`, `dev_base` and `glob_ctrl` therefore change one edge after the strobe, and the bench reads them on the falling edge that follows. Read answers arrive one edge after `io_rd`. A driver task queues the expected byte for each read, and a monitor takes the byte off the queue on every falling edge where `rd_valid` is high. A pulse that arrives with an empty queue counts as a mismatch, and so does an entry that is never answered. For strobes to other addresses, the bench checks that `rd_valid` stays low on the cycle where an answer would otherwise be due.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam logic [7:0] KEY_OPEN_A  = 8'h80;
  localparam logic [7:0] KEY_OPEN_B  = 8'h86;
  localparam logic [7:0] KEY_CLOSE_A = 8'h68;
  localparam logic [7:0] KEY_CLOSE_B = 8'h08;

  localparam logic [7:0] IX_LDN   = 8'h07;
  localparam logic [7:0] IX_GLOB  = 8'h29;
  localparam logic [7:0] IX_ACT   = 8'h30;
  localparam logic [7:0] IX_BASEH = 8'h60;
  localparam logic [7:0] IX_BASEL = 8'h61;

  localparam logic [7:0] LOCKED_READ = 8'hFF;

  typedef enum logic [1:0] {
    KS_SHUT,
    KS_SHUT_HALF,
    KS_OPEN,
    KS_OPEN_HALF
  } key_state_e;
endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       open_o
);
  key_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (idx_wr) begin
      unique case (st_q)
        KS_SHUT:      st_d = (wdata == KEY_OPEN_A) ? KS_SHUT_HALF : KS_SHUT;
        KS_SHUT_HALF: st_d = (wdata == KEY_OPEN_B)  ? KS_OPEN :
                             (wdata == KEY_OPEN_A)  ? KS_SHUT_HALF : KS_SHUT;
        KS_OPEN:      st_d = (wdata == KEY_CLOSE_A) ? KS_OPEN_HALF : KS_OPEN;
        KS_OPEN_HALF: st_d = (wdata == KEY_CLOSE_B) ? KS_SHUT :
                             (wdata == KEY_CLOSE_A) ? KS_OPEN_HALF : KS_OPEN;
        default:      st_d = KS_SHUT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= KS_SHUT;
    else        st_q <= st_d;
  end

  assign open_o = (st_q == KS_OPEN) || (st_q == KS_OPEN_HALF);

  // R2: opening is always caused by the second unlock byte
  p_open_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_o) |-> $past(idx_wr && wdata == KEY_OPEN_B));

  // R5: closing is always caused by the second exit byte
  p_close_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(open_o) |-> $past(idx_wr && wdata == KEY_CLOSE_B));

  // R4: without an index write the lock state holds
  p_lock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_wr |=> $stable(open_o));
endmodule

// File: rtl/sio_ldev_regs.sv
module sio_ldev_regs
  import sio_cfg_pkg::*;
#(
  parameter logic [7:0] LDN_ID = 8'h04
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  ldn,
  input  logic [7:0]  idx,
  input  logic [7:0]  wdata,
  output logic        en_o,
  output logic [15:0] base_o,
  output logic [7:0]  rdata_o
);
  logic       sel;
  logic       en_q;
  logic [7:0] hi_q, lo_q;

  assign sel = (ldn == LDN_ID);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      hi_q <= '0;
      lo_q <= '0;
    end else if (wr_en && sel) begin
      unique case (idx)
        IX_ACT:   en_q <= wdata[0];
        IX_BASEH: hi_q <= wdata;
        IX_BASEL: lo_q <= wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel) begin
      unique case (idx)
        IX_ACT:   rdata_o = {7'b0, en_q};
        IX_BASEH: rdata_o = hi_q;
        IX_BASEL: rdata_o = lo_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign en_o   = en_q;
  assign base_o = {hi_q, lo_q};

  // R8: the base address moves only on a write strobe
  p_base_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(base_o));

  // R7: the activate bit follows only writes aimed at this device
  p_en_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ldn != LDN_ID) |=> $stable(en_o));
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] BASE_ADDR = 16'h002E,
  parameter int          NUM_LDN   = 3,
  parameter int          FIRST_LDN = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     io_addr,
  input  logic                  io_wr,
  input  logic                  io_rd,
  input  logic [7:0]            io_wdata,
  output logic                  rd_valid,
  output logic [7:0]            rd_data,
  output logic                  cfg_open,
  output logic [NUM_LDN-1:0]    dev_en,
  output logic [16*NUM_LDN-1:0] dev_base,
  output logic [7:0]            glob_ctrl
);
  localparam logic [ADDR_W-1:0] IDX_PORT = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] DAT_PORT = ADDR_W'(BASE_ADDR + 16'd1);

  logic       hit_idx, hit_dat;
  logic       idx_wr, dat_wr;
  logic [7:0] idx_q, ldn_q, glob_q;
  logic [7:0] rd_mux, rd_q;
  logic       rv_q;
  logic [7:0] dev_rd [NUM_LDN];

  assign hit_idx = (io_addr == IDX_PORT);
  assign hit_dat = (io_addr == DAT_PORT);
  assign idx_wr  = io_wr && hit_idx;
  assign dat_wr  = io_wr && hit_dat && cfg_open;

  sio_key_fsm u_key (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx_wr (idx_wr),
    .wdata  (io_wdata),
    .open_o (cfg_open)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      ldn_q  <= '0;
      glob_q <= '0;
    end else begin
      if (idx_wr && cfg_open) idx_q <= io_wdata;
      if (dat_wr && idx_q == IX_LDN) ldn_q <= io_wdata;
      if (dat_wr && idx_q == IX_GLOB && ldn_q == 8'h00) glob_q <= io_wdata;
    end
  end

  for (genvar k = 0; k < NUM_LDN; k++) begin : g_dev
    sio_ldev_regs #(.LDN_ID(8'(FIRST_LDN + k))) u_ldev (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (dat_wr),
      .ldn     (ldn_q),
      .idx     (idx_q),
      .wdata   (io_wdata),
      .en_o    (dev_en[k]),
      .base_o  (dev_base[16*k +: 16]),
      .rdata_o (dev_rd[k])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (idx_q == IX_LDN) begin
      rd_mux = ldn_q;
    end else if (idx_q == IX_GLOB) begin
      rd_mux = (ldn_q == 8'h00) ? glob_q : 8'h00;
    end else begin
      for (int k = 0; k < NUM_LDN; k++) rd_mux = rd_mux | dev_rd[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rd_q <= '0;
    end else begin
      rv_q <= io_rd && (hit_idx || hit_dat);
      if (io_rd) rd_q <= !cfg_open ? LOCKED_READ : (hit_idx ? idx_q : rd_mux);
    end
  end

  assign rd_valid  = rv_q;
  assign rd_data   = rd_q;
  assign glob_ctrl = glob_q;

  // R9: the global byte is frozen while another device is selected
  p_glob_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ldn_q != 8'h00) |=> $stable(glob_ctrl));

  // R4: locked reads answer 0xFF
  p_locked_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !cfg_open && hit_dat) |=> (rd_valid && rd_data == LOCKED_READ));

  // R4: nothing in the register file moves while locked
  p_locked_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> ($stable(dev_en) && $stable(dev_base) && $stable(glob_ctrl)));

  // R11: no read strobe, no valid pulse
  p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> !rd_valid);
endmodule

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb;
  localparam logic [15:0] IDXP = 16'h002E;
  localparam logic [15:0] DATP = 16'h002F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        cfg_open;
  logic [2:0]  dev_en;
  logic [47:0] dev_base;
  logic [7:0]  glob_ctrl;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2.5 clk = ~clk;

  sio_cfg_port u_dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .cfg_open(cfg_open), .dev_en(dev_en), .dev_base(dev_base), .glob_ctrl(glob_ctrl)
  );

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic reg_wr(input logic [7:0] ix, input logic [7:0] d);
    wr(IDXP, ix);
    wr(DATP, d);
  endtask

  task automatic reg_rd(input logic [7:0] ix, input logic [7:0] exp, input string tag);
    wr(IDXP, ix);
    rd(DATP, exp, tag);
  endtask

  // monitor: compare each read answer against the queued expectation
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R11: unexpected rd_valid, actual %0h expected none", rd_data);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, {40'b0, rd_data}, {40'b0, e});
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 open", {47'b0, cfg_open}, 48'd0);
    chk("R1 en", {45'b0, dev_en}, 48'd0);
    chk("R1 base", dev_base, 48'd0);
    chk("R1 glob", {40'b0, glob_ctrl}, 48'd0);

    // R4 locked: read FF, writes ignored
    rd(DATP, 8'hFF, "R4 locked data read");
    rd(IDXP, 8'hFF, "R4 locked index read");
    wr(IDXP, 8'h07);
    wr(DATP, 8'h05);

    // R3 broken key stays locked
    wr(IDXP, 8'h80); wr(IDXP, 8'h12); wr(IDXP, 8'h86);
    chk("R3 broken key", {47'b0, cfg_open}, 48'd0);
    // R3 repeated first byte restarts
    wr(IDXP, 8'h80); wr(IDXP, 8'h80); wr(IDXP, 8'h86);
    chk("R3 restart key", {47'b0, cfg_open}, 48'd1);

    // R4 locked write had no effect on LDN
    reg_rd(8'h07, 8'h00, "R4 ldn untouched");
    // R12 index port readback
    rd(IDXP, 8'h07, "R12 index read");

    // R6 LDN write/read
    reg_wr(8'h07, 8'h04);
    reg_rd(8'h07, 8'h04, "R6 ldn readback");
    // R7 activate
    reg_wr(8'h30, 8'hFF);
    chk("R7 en dev4", {45'b0, dev_en}, 48'h1);
    reg_rd(8'h30, 8'h01, "R7 act readback");
    // R8 base on ldn 5
    reg_wr(8'h07, 8'h05);
    reg_wr(8'h60, 8'h12);
    reg_wr(8'h61, 8'h34);
    chk("R8 base dev5", dev_base, 48'h0000_1234_0000);
    reg_rd(8'h60, 8'h12, "R8 hi readback");
    reg_rd(8'h61, 8'h34, "R8 lo readback");
    // R7 ldn 6
    reg_wr(8'h07, 8'h06);
    reg_wr(8'h30, 8'h01);
    chk("R7 en dev6", {45'b0, dev_en}, 48'h5);

    // R9 global gated by LDN
    reg_wr(8'h29, 8'h0B);
    chk("R9 glob gated", {40'b0, glob_ctrl}, 48'h0);
    reg_rd(8'h29, 8'h00, "R9 glob read gated");
    reg_wr(8'h07, 8'h00);
    reg_wr(8'h29, 8'h0B);
    chk("R9 glob written", {40'b0, glob_ctrl}, 48'h0B);
    reg_rd(8'h29, 8'h0B, "R9 glob readback");

    // R10 unimplemented indices and unselected device
    reg_wr(8'h30, 8'h00);
    chk("R10 no device", {45'b0, dev_en}, 48'h5);
    reg_wr(8'h07, 8'h04);
    reg_wr(8'h31, 8'h77);
    reg_rd(8'h31, 8'h00, "R10 unimpl read");
    chk("R10 outputs", {dev_base[31:0], 13'b0, dev_en}, {32'h1234_0000, 16'h0005});
    reg_wr(8'h07, 8'h03);
    reg_rd(8'h60, 8'h00, "R10 unselected read");

    // R11 foreign address gives no answer
    io_addr = 16'h0030; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    chk("R11 foreign read", {47'b0, rd_valid}, 48'd0);
    @(negedge clk);

    // R5 exit key
    wr(IDXP, 8'h68); wr(IDXP, 8'h99);
    chk("R5 broken exit", {47'b0, cfg_open}, 48'd1);
    wr(IDXP, 8'h68); wr(IDXP, 8'h08);
    chk("R5 locked", {47'b0, cfg_open}, 48'd0);
    chk("R5 outputs kept", {dev_base[31:16], 29'b0, dev_en}, {16'h1234, 32'h5});
    rd(DATP, 8'hFF, "R5 locked read");

    // R2 plain unlock
    wr(IDXP, 8'h80); wr(IDXP, 8'h86);
    chk("R2 unlock", {47'b0, cfg_open}, 48'd1);
    reg_rd(8'h07, 8'h03, "R2 open access");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R11: actual %0d reads unanswered expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule